// File: doc/BRIEF.md
# Periodic Tick Interrupt and Read-Rollover Monitor

This block sits on an 8-bit register bus beside a time-of-day counter. It receives eight single-cycle event pulses (alarm match, month, week, day, hour, minute, second and tenth-of-a-second rollovers), gates them with a software-written enable mask and latches the enabled ones into a status register. Any set status bit drives an active-high interrupt line. Software reads the status register to learn which sources fired, and the status register empties when that read strobe is removed.

A second function guards multi-byte counter reads. Once software has read any counter address, a 1 kHz tick arriving during or after that read raises a rollover flag. Software reads the flag after its counter reads, and if the flag is set it knows the captured time may be torn and reads again. Reading the flag clears it when the strobe ends.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After a synchronous reset the enable mask, status register, rollover flag, interrupt line and read data are all zero.
- R2: A write cycle at address 11h loads the enable mask from the write data; reading 11h returns the mask.
- R3: An event pulse whose enable bit is 1 sets its status bit at the next clock edge, and the interrupt line is high in that same cycle. Bit mapping: bit0 alarm match, bit1 month, bit2 week, bit3 day, bit4 hour, bit5 minute, bit6 second, bit7 tenth-second.
- R4: A pulse whose enable bit is 0 never sets a status bit, and clearing an enable bit leaves an already-set status bit set.
- R5: While the read strobe is high at address 10h, the read data carries the status register, one cycle behind the strobe's first cycle.
- R6: The clock edge at which the read strobe is seen low after a read of 10h clears the status register and drops the interrupt line.
- R7: An enabled event pulse in the same cycle as that clearing edge is kept: its status bit is set afterwards.
- R8: The rollover flag sets when the 1 kHz tick is high in a cycle where a counter address (00h to 07h) is being read, or at any later cycle after such a read.
- R9: A tick with no counter read since the last flag clear leaves the flag at zero.
- R10: Reading address 14h returns the flag on bit 0 with bits 7..1 zero; the end of that read clears the flag and forgets earlier counter reads.
- R11: The interrupt line is high exactly when at least one status bit is set.
- R12: When the read strobe is low the read data is zero one cycle later; unused addresses (for example 1Fh) read as zero, and a write to 10h leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address, stable while a strobe is high |
| bus_rd | input | 1 | Read strobe, high for the whole read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_pulse | input | 8 | Event pulses, one bit per source |
| tick_1k | input | 1 | 1 kHz tick, one cycle wide |
| irq | output | 1 | Active-high interrupt |

## Verification
Every result is a single register away from its cause: a status bit, the interrupt line and the rollover flag change at the first clock edge that sees the pulse, the tick or the strobe's removal, and read data follows the strobe by one edge. The bench drives inputs on the falling clock edge and samples on the next falling edge, so each check lands exactly one rising edge after its stimulus. Clearing is checked both at the port (interrupt line low) and by a fresh read, and the coincident-event case places the pulse on the very falling edge where the strobe is dropped.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  // Source bit positions shared by enable mask and status register
  localparam int unsigned SRC_ALARM  = 0;
  localparam int unsigned SRC_MONTH  = 1;
  localparam int unsigned SRC_WEEK   = 2;
  localparam int unsigned SRC_DAY    = 3;
  localparam int unsigned SRC_HOUR   = 4;
  localparam int unsigned SRC_MINUTE = 5;
  localparam int unsigned SRC_SECOND = 6;
  localparam int unsigned SRC_TENTH  = 7;

  // Which register the read mux presents
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_ROLL = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/tick_bus_decode.sv
module tick_bus_decode
  import tick_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned STAT_ADDR = 16,
  parameter int unsigned MASK_ADDR = 17,
  parameter int unsigned ROLL_ADDR = 20,
  parameter int unsigned CNT_LAST  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output rd_sel_e           rd_sel,
  output logic              mask_we,
  output logic              cnt_rd,
  output logic              stat_rd_end,
  output logic              roll_rd_end
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] A_ROLL = ADDR_W'(ROLL_ADDR);
  localparam logic [ADDR_W-1:0] A_CNTL = ADDR_W'(CNT_LAST);

  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= rd;
      addr_q <= addr;
    end
  end

  logic rd_fall;
  assign rd_fall = rd_q && !rd;

  always_comb begin
    rd_sel = SEL_NONE;
    if (addr == A_STAT)      rd_sel = SEL_STAT;
    else if (addr == A_MASK) rd_sel = SEL_MASK;
    else if (addr == A_ROLL) rd_sel = SEL_ROLL;
  end

  assign mask_we     = wr && (addr == A_MASK);
  assign cnt_rd      = rd && (addr <= A_CNTL);
  assign stat_rd_end = rd_fall && (addr_q == A_STAT);
  assign roll_rd_end = rd_fall && (addr_q == A_ROLL);

  // The two end-of-read pulses target different addresses
  assert_one_end_R6: assert property (@(posedge clk) disable iff (rst)
    !(stat_rd_end && roll_rd_end));
endmodule

// File: rtl/tick_irq_status.sv
module tick_irq_status #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             clr,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] status_q,
  output logic             irq_q
);
  logic [N_SRC-1:0] gated;
  logic [N_SRC-1:0] status_n;

  // One gate per source
  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    assign gated[g] = evt[g] & mask_q[g];
  end

  always_comb begin
    status_n = clr ? '0 : status_q;
    status_n = status_n | gated;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      status_q <= status_n;
      irq_q    <= |status_n;
    end
  end

  assert_irq_any_R11: assert property (@(posedge clk) disable iff (rst)
    irq_q == (status_q != '0));

  assert_masked_no_set_R4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((status_q & ~$past(status_q) & ~$past(mask_q)) == '0));

  assert_hold_no_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_clear_keep_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (status_q == $past(evt & mask_q)));
endmodule

// File: rtl/tick_rollover_flag.sv
module tick_rollover_flag (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cnt_rd,
  input  logic clr,
  output logic flag_q
);
  logic armed_q;
  logic watching;

  assign watching = armed_q | cnt_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (clr) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      armed_q <= watching;
      flag_q  <= flag_q | (tick & watching);
    end
  end

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag_q);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_rd && !clr) |=> flag_q);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/tick_read_mux.sv
module tick_read_mux
  import tick_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  rd_sel_e           sel,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] mask,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    unique case (sel)
      SEL_STAT: pick = status;
      SEL_MASK: pick = mask;
      SEL_ROLL: pick = {{(DATA_W-1){1'b0}}, flag};
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= pick;
    else         rdata_q <= '0;
  end

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata_q == '0));
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tick_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STAT_ADDR = 16,
  parameter int unsigned MASK_ADDR = 17,
  parameter int unsigned ROLL_ADDR = 20,
  parameter int unsigned CNT_LAST  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_pulse,
  input  logic              tick_1k,
  output logic              irq
);
  rd_sel_e           rd_sel;
  logic              mask_we;
  logic              cnt_rd;
  logic              stat_rd_end;
  logic              roll_rd_end;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status_q;
  logic              flag_q;

  tick_bus_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR),
    .ROLL_ADDR(ROLL_ADDR), .CNT_LAST(CNT_LAST)
  ) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .rd_sel(rd_sel), .mask_we(mask_we), .cnt_rd(cnt_rd),
    .stat_rd_end(stat_rd_end), .roll_rd_end(roll_rd_end)
  );

  tick_irq_status #(.N_SRC(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .evt(evt_pulse), .mask_we(mask_we),
    .mask_wdata(bus_wdata), .clr(stat_rd_end),
    .mask_q(mask_q), .status_q(status_q), .irq_q(irq)
  );

  tick_rollover_flag u_roll (
    .clk(clk), .rst(rst), .tick(tick_1k), .cnt_rd(cnt_rd),
    .clr(roll_rd_end), .flag_q(flag_q)
  );

  tick_read_mux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst(rst), .rd(bus_rd), .sel(rd_sel),
    .status(status_q), .mask(mask_q), .flag(flag_q), .rdata_q(bus_rdata)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && bus_rdata == '0));
endmodule

// File: tb/test_tick_irq_ctrl.sv
module test_tick_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] evt_pulse = '0;
  logic       tick_1k = 1'b0;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_irq_ctrl i_tick_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .tick_1k(tick_1k), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  // Full read: strobe one cycle, sample, drop, wait for the clearing edge
  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic pulse_tick;
    @(negedge clk); tick_1k = 1'b1;
    @(negedge clk); tick_1k = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rd_reg(5'h11, d); check("R1 mask", d, 8'h00);
    rd_reg(5'h10, d); check("R1 status", d, 8'h00);
    rd_reg(5'h14, d); check("R1 flag", d, 8'h00);
  endtask

  task automatic t_mask_rw;
    logic [7:0] d;
    wr_reg(5'h11, 8'hA5);
    rd_reg(5'h11, d); check("R2 mask A5", d, 8'hA5);
    wr_reg(5'h11, 8'h5A);
    rd_reg(5'h11, d); check("R2 mask 5A", d, 8'h5A);
  endtask

  task automatic t_enabled_event;
    logic [7:0] d;
    wr_reg(5'h11, 8'h41);
    @(negedge clk); evt_pulse = 8'h40;
    @(negedge clk); evt_pulse = '0;
    check("R3 irq after second pulse", {7'd0, irq}, 8'h01);
    pulse_evt(8'h01);
    // R5: data one cycle behind strobe start
    @(negedge clk); bus_addr = 5'h10; bus_rd = 1'b1;
    @(negedge clk);
    check("R5 status on bus", bus_rdata, 8'h41);
    check("R11 irq while set", {7'd0, irq}, 8'h01);
    bus_rd = 1'b0;
    @(negedge clk);
    check("R6 irq after read end", {7'd0, irq}, 8'h00);
    check("R12 idle rdata", bus_rdata, 8'h00);
    rd_reg(5'h10, d); check("R6 status cleared", d, 8'h00);
  endtask

  task automatic t_disabled_event;
    logic [7:0] d;
    wr_reg(5'h11, 8'h01);
    pulse_evt(8'h10);
    check("R4 irq masked", {7'd0, irq}, 8'h00);
    rd_reg(5'h10, d); check("R4 status masked", d, 8'h00);
    wr_reg(5'h11, 8'h10);
    pulse_evt(8'h10);
    wr_reg(5'h11, 8'h00);
    check("R4 irq kept after disable", {7'd0, irq}, 8'h01);
    rd_reg(5'h10, d); check("R4 status kept after disable", d, 8'h10);
  endtask

  task automatic t_coincident;
    logic [7:0] d;
    wr_reg(5'h11, 8'hFF);
    pulse_evt(8'h80);
    @(negedge clk); bus_addr = 5'h10; bus_rd = 1'b1;
    @(negedge clk);
    check("R5 tenth-second bit", bus_rdata, 8'h80);
    bus_rd = 1'b0; evt_pulse = 8'h20;
    @(negedge clk); evt_pulse = '0;
    check("R7 irq kept", {7'd0, irq}, 8'h01);
    rd_reg(5'h10, d); check("R7 coincident minute bit", d, 8'h20);
    check("R6 cleared again", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_roll_during;
    logic [7:0] d;
    @(negedge clk); bus_addr = 5'h05; bus_rd = 1'b1; tick_1k = 1'b1;
    @(negedge clk); bus_rd = 1'b0; tick_1k = 1'b0;
    @(negedge clk);
    rd_reg(5'h14, d); check("R8 tick during counter read", d, 8'h01);
    rd_reg(5'h14, d); check("R10 flag cleared", d, 8'h00);
  endtask

  task automatic t_roll_after;
    logic [7:0] d;
    rd_reg(5'h03, d);
    repeat (3) @(negedge clk);
    rd_reg(5'h14, d); check("R8 no tick yet", d, 8'h00);
    rd_reg(5'h07, d);
    repeat (2) @(negedge clk);
    pulse_tick();
    rd_reg(5'h14, d); check("R10 flag on bit0", d, 8'h01);
    pulse_tick();
    rd_reg(5'h14, d); check("R10 arming forgotten", d, 8'h00);
  endtask

  task automatic t_no_read;
    logic [7:0] d;
    pulse_tick();
    rd_reg(5'h10, d);
    pulse_tick();
    rd_reg(5'h14, d); check("R9 tick without counter read", d, 8'h00);
  endtask

  task automatic t_unused;
    logic [7:0] d;
    wr_reg(5'h10, 8'hFF);
    check("R12 write to status ignored irq", {7'd0, irq}, 8'h00);
    rd_reg(5'h10, d); check("R12 write to status ignored", d, 8'h00);
    rd_reg(5'h1F, d); check("R12 unused address", d, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask_rw();
    t_enabled_event();
    t_disabled_event();
    t_coincident();
    t_roll_during();
    t_roll_after();
    t_no_read();
    t_unused();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule